// File: doc/BRIEF.md
# Stub Level-2 Cache Controller Register Block

This block answers register accesses aimed at a level-2 cache controller on a system where no such cache is actually built. Software that probes, configures and maintains the cache finds the registers it expects. Settings it writes are kept and read back. Maintenance operations it issues are reported as already finished. The block holds no tag storage and no data storage, and it performs no caching of any kind.

Accesses arrive on a simple synchronous port with separate read and write strobes. Only the low twelve address bits select a register, so the block fills a 4 KB window and repeats across any larger region. The block holds six writable settings: enable, auxiliary configuration, tag-array timing, data-array timing, and the two bounds of an address filter. It also returns a fixed identity word and a cache-type word. The cache-type word absorbs the way-size and associativity fields of the auxiliary setting each time it is read. The `CTYPE_BASE` parameter sets the starting value of the cache-type word.

Top module: `l2stub_regs`

## Requirements
- R1: Only address bits 11:0 select a register. Two addresses that share those bits behave identically, whatever their upper bits.
- R2: A read of offset 0x000 returns 0x410000C8.
- R3: Six settings can be written and read back at these offsets: enable 0x100, auxiliary 0x104, tag timing 0x108, data timing 0x10C, filter start 0xC00 and filter end 0xC04. All of them except the enable register keep all 32 bits.
- R4: A write to the enable register stores only wdata bit 0. Bits 31:1 read back as zero.
- R5: For any offset from 0x730 to 0x7FF inclusive:
  - a read returns zero, meaning the maintenance operation is idle;
  - a write changes nothing.
- R6: A read of offset 0x004 first forms a 5-bit field F, where F[4:2] is auxiliary bits 19:17, F[1] is 0 and F[0] is auxiliary bit 16. It then ORs F<<18 and F<<6 into the cache-type word and returns the updated word. Bits set this way stay set until reset.
- R7: After reset, the cache-type word equals `CTYPE_BASE`, which defaults to 0x1C100100.
- R8: Reset values are as follows:
  - the auxiliary register loads 0x02020000;
  - every other setting clears to zero;
  - rdata and bad_acc are 0.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read zero and ignore writes. They do not raise bad_acc.
- R10: Any other access is a bad access. This covers reads of unmapped offsets, and writes to unmapped offsets, to 0x000 or to 0x004. A bad read returns zero and a bad write changes nothing. In either case bad_acc is 1 in the cycle after the strobe, and it is 0 after any cycle with no strobe.
- R11: rdata changes only in the cycle after a read strobe and holds its value otherwise. A write takes effect at the clock edge where wr_en is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| addr | input | ADDR_W | Byte address; only bits 11:0 are decoded |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data, valid one cycle after rd_en |
| bad_acc | output | 1 | One-cycle flag for an access to an undecoded offset |

## Verification
The assertions assume three things about the inputs:
- read and write strobes are never high in the same cycle;
- reset is held for more than one clock before the first access;
- any address bits above bit 11 may take any value.

The bench drives at most one strobe per cycle and releases reset only after four cycles. It randomizes the upper address bits on every access, so aliasing is exercised together with the directed offsets.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;

    localparam int OFS_W = 12;

    typedef enum logic [3:0] {
        SEL_ID,
        SEL_CTYPE,
        SEL_CTRL,
        SEL_AUX,
        SEL_TAGC,
        SEL_DATAC,
        SEL_FSTART,
        SEL_FEND,
        SEL_MAINT,
        SEL_QUIET,
        SEL_NONE
    } sel_e;

    localparam logic [OFS_W-1:0] OFS_ID      = 12'h000;
    localparam logic [OFS_W-1:0] OFS_CTYPE   = 12'h004;
    localparam logic [OFS_W-1:0] OFS_CTRL    = 12'h100;
    localparam logic [OFS_W-1:0] OFS_AUX     = 12'h104;
    localparam logic [OFS_W-1:0] OFS_TAGC    = 12'h108;
    localparam logic [OFS_W-1:0] OFS_DATAC   = 12'h10C;
    localparam logic [OFS_W-1:0] OFS_FSTART  = 12'hC00;
    localparam logic [OFS_W-1:0] OFS_FEND    = 12'hC04;
    localparam logic [OFS_W-1:0] OFS_MNT_LO  = 12'h730;
    localparam logic [OFS_W-1:0] OFS_MNT_HI  = 12'h7FF;
    localparam logic [OFS_W-1:0] OFS_QUIET0  = 12'hF40;
    localparam logic [OFS_W-1:0] OFS_QUIET1  = 12'hF60;
    localparam logic [OFS_W-1:0] OFS_QUIET2  = 12'hF80;

    localparam logic [31:0] ID_WORD = 32'h410000C8;
    localparam logic [31:0] AUX_RST = 32'h02020000;

endpackage

// File: rtl/l2stub_decode.sv
module l2stub_decode
    import l2stub_pkg::*;
(
    input  logic [OFS_W-1:0] ofs,
    input  logic             is_write,
    output sel_e             sel,
    output logic             bad
);

    always_comb begin
        if (ofs >= OFS_MNT_LO && ofs <= OFS_MNT_HI) begin
            sel = SEL_MAINT;
        end else begin
            unique case (ofs)
                OFS_ID:     sel = SEL_ID;
                OFS_CTYPE:  sel = SEL_CTYPE;
                OFS_CTRL:   sel = SEL_CTRL;
                OFS_AUX:    sel = SEL_AUX;
                OFS_TAGC:   sel = SEL_TAGC;
                OFS_DATAC:  sel = SEL_DATAC;
                OFS_FSTART: sel = SEL_FSTART;
                OFS_FEND:   sel = SEL_FEND;
                OFS_QUIET0, OFS_QUIET1, OFS_QUIET2: sel = SEL_QUIET;
                default:    sel = SEL_NONE;
            endcase
        end
    end

    // Identity and cache-type offsets are read-only; a write there is bad.
    always_comb begin
        bad = (sel == SEL_NONE) ||
              (is_write && (sel == SEL_ID || sel == SEL_CTYPE));
    end

endmodule

// File: rtl/l2stub_ctype.sv
module l2stub_ctype #(
    parameter int              DATA_W = 32,
    parameter logic [DATA_W-1:0] BASE = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] aux,
    input  logic              fold_en,
    output logic [DATA_W-1:0] ctype_now
);

    localparam int FLD_W      = 5;
    localparam int POS_HI     = 18;
    localparam int POS_LO     = 6;
    localparam int AUX_ASSOC  = 16;
    localparam int AUX_WAY_LO = 17;

    typedef struct packed {
        logic [DATA_W-1:0] ctype;
    } ct_st_t;

    ct_st_t st_d, st_q;
    logic [FLD_W-1:0]  fld;
    logic [DATA_W-1:0] mask;

    always_comb begin
        fld       = {aux[AUX_WAY_LO+2:AUX_WAY_LO], 1'b0, aux[AUX_ASSOC]};
        mask      = (DATA_W'(fld) << POS_HI) | (DATA_W'(fld) << POS_LO);
        ctype_now = st_q.ctype | mask;
        st_d      = st_q;
        if (fold_en) begin
            st_d.ctype = ctype_now;
        end
        if (rst) begin
            st_d.ctype = BASE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R6: once set, a cache-type bit never clears outside reset
    p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        (st_q.ctype & $past(st_q.ctype)) == $past(st_q.ctype));

endmodule

// File: rtl/l2stub_regs.sv
module l2stub_regs
    import l2stub_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter logic [DATA_W-1:0] CTYPE_BASE = DATA_W'(32'h1C100100)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              bad_acc
);

    localparam int NREG  = 6;
    localparam int IDX_W = $clog2(NREG);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] rw;
        logic [DATA_W-1:0]           rdata;
        logic                        bad;
    } st_t;

    st_t st_d, st_q;

    logic [OFS_W-1:0]  ofs;
    sel_e              sel;
    logic              dec_bad;
    logic              is_rw;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] ctype_now;
    logic              fold_en;

    assign ofs = addr[OFS_W-1:0];

    l2stub_decode u_dec (
        .ofs      (ofs),
        .is_write (wr_en),
        .sel      (sel),
        .bad      (dec_bad)
    );

    assign fold_en = rd_en && (sel == SEL_CTYPE);

    l2stub_ctype #(
        .DATA_W (DATA_W),
        .BASE   (CTYPE_BASE)
    ) u_ct (
        .clk       (clk),
        .rst       (rst),
        .aux       (st_q.rw[int'(SEL_AUX) - int'(SEL_CTRL)]),
        .fold_en   (fold_en),
        .ctype_now (ctype_now)
    );

    function automatic logic [DATA_W-1:0] wmask(input logic [IDX_W-1:0] i);
        return (i == '0) ? DATA_W'(1) : '1;
    endfunction

    always_comb begin
        is_rw = (sel >= SEL_CTRL) && (sel <= SEL_FEND);
        idx   = IDX_W'(int'(sel) - int'(SEL_CTRL));
        st_d     = st_q;
        st_d.bad = (rd_en || wr_en) && dec_bad;
        if (wr_en && is_rw) begin
            st_d.rw[idx] = wdata & wmask(idx);
        end
        if (rd_en) begin
            case (sel)
                SEL_ID:    st_d.rdata = DATA_W'(ID_WORD);
                SEL_CTYPE: st_d.rdata = ctype_now;
                default:   st_d.rdata = is_rw ? st_q.rw[idx] : '0;
            endcase
        end
        if (rst) begin
            st_d.rw    = '0;
            st_d.rw[int'(SEL_AUX) - int'(SEL_CTRL)] = DATA_W'(AUX_RST);
            st_d.rdata = '0;
            st_d.bad   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign rdata   = st_q.rdata;
    assign bad_acc = st_q.bad;

    logic [NREG-1:0][DATA_W-1:0] rw_q;
    logic in_mnt;
    assign rw_q   = st_q.rw;
    assign in_mnt = (ofs >= OFS_MNT_LO) && (ofs <= OFS_MNT_HI);

    p_id_r2: assert property (@(posedge clk) disable iff (rst)
        rd_en && ofs == OFS_ID |=> rdata == DATA_W'(ID_WORD));

    p_ctrl_bit0_r4: assert property (@(posedge clk) disable iff (rst)
        rd_en && ofs == OFS_CTRL |=> rdata[DATA_W-1:1] == '0);

    p_mnt_rd_r5: assert property (@(posedge clk) disable iff (rst)
        rd_en && in_mnt |=> rdata == '0);

    p_mnt_wr_r5: assert property (@(posedge clk) disable iff (rst)
        wr_en && in_mnt |=> $stable(rw_q));

    p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) && (ofs == OFS_QUIET0 || ofs == OFS_QUIET1 ||
        ofs == OFS_QUIET2) |=> !bad_acc);

    p_bad_flag_r10: assert property (@(posedge clk) disable iff (rst)
        (rd_en || wr_en) && dec_bad |=> bad_acc);

    p_bad_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !(rd_en || wr_en) |=> !bad_acc);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rdata));

endmodule

// File: tb/sim_l2stub_regs.sv
module sim_l2stub_regs;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        bad_acc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    l2stub_regs u0 (
        .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .bad_acc(bad_acc)
    );

    // reference model state
    logic [31:0] m_ctrl, m_aux, m_tag, m_dat, m_fs, m_fe, m_ct;
    logic [31:0] last_rd;

    task automatic model_reset();
        m_ctrl = 0; m_aux = 32'h02020000; m_tag = 0; m_dat = 0;
        m_fs = 0; m_fe = 0; m_ct = 32'h1C100100; last_rd = 0;
    endtask

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model(input bit wr, input logic [11:0] o, input logic [31:0] wd,
                         output logic [31:0] rv, output bit bad);
        logic [4:0] f;
        rv = 0; bad = 0;
        if (o >= 12'h730 && o <= 12'h7FF) begin
            rv = 0;
        end else begin
            case (o)
                12'h000: if (wr) bad = 1; else rv = 32'h410000C8;
                12'h004: if (wr) bad = 1; else begin
                    f = {m_aux[19:17], 1'b0, m_aux[16]};
                    m_ct = m_ct | ({27'd0, f} << 18) | ({27'd0, f} << 6);
                    rv = m_ct;
                end
                12'h100: if (wr) m_ctrl = {31'd0, wd[0]}; else rv = m_ctrl;
                12'h104: if (wr) m_aux = wd; else rv = m_aux;
                12'h108: if (wr) m_tag = wd; else rv = m_tag;
                12'h10C: if (wr) m_dat = wd; else rv = m_dat;
                12'hC00: if (wr) m_fs = wd; else rv = m_fs;
                12'hC04: if (wr) m_fe = wd; else rv = m_fe;
                12'hF40, 12'hF60, 12'hF80: rv = 0;
                default: bad = 1;
            endcase
        end
    endtask

    task automatic access(input bit wr, input logic [31:0] a, input logic [31:0] wd,
                          input string req);
        logic [31:0] ev;
        bit eb;
        model(wr, a[11:0], wd, ev, eb);
        @(negedge clk);
        rd_en = !wr; wr_en = wr; addr = a; wdata = wd;
        @(negedge clk);
        rd_en = 0; wr_en = 0;
        if (!wr) begin
            check(rdata == ev, req, rdata, ev);
            last_rd = ev;
        end
        check(bad_acc == eb, {req, " (R10 flag)"}, {31'd0, bad_acc}, {31'd0, eb});
    endtask

    function automatic logic [11:0] pick_ofs(input int unsigned r);
        case (r % 16)
            0: return 12'h000;   1: return 12'h004;
            2: return 12'h100;   3: return 12'h104;
            4: return 12'h108;   5: return 12'h10C;
            6: return 12'hC00;   7: return 12'hC04;
            8: return 12'h730 + 12'((r >> 8) % 208);
            9: return 12'hF40;  10: return 12'hF60;
            11: return 12'hF80; 12: return 12'h104;
            13: return 12'h004;
            default: return 12'(r >> 4);
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check(rdata == 0, "R8 rdata reset", rdata, 0);
        check(bad_acc == 0, "R8 bad_acc reset", {31'd0, bad_acc}, 0);

        // R8 reset values of settings
        access(0, 32'h100, 0, "R8 ctrl reset");
        access(0, 32'h104, 0, "R8 aux reset");
        access(0, 32'h108, 0, "R8 tag reset");
        access(0, 32'h10C, 0, "R8 data reset");
        access(0, 32'hC00, 0, "R8 fstart reset");
        access(0, 32'hC04, 0, "R8 fend reset");
        // R7 base value (reset aux folds to bits already set)
        access(0, 32'h004, 0, "R7 ctype base");
        // R2 identity, R1 alias with upper bits
        access(0, 32'h000, 0, "R2 id");
        access(0, 32'hABCD_E000, 0, "R1 id alias");
        access(1, 32'h5555_5108, 32'hDEADBEEF, "R1 alias write");
        access(0, 32'h0000_0108, 0, "R1 alias readback");
        // R3 round trip
        access(1, 32'hC00, 32'h8000_0001, "R3 fstart write");
        access(0, 32'hC00, 0, "R3 fstart read");
        access(1, 32'hC04, 32'h7FFF_FFFE, "R3 fend write");
        access(0, 32'hC04, 0, "R3 fend read");
        // R4 enable bit only
        access(1, 32'h100, 32'hFFFF_FFFF, "R4 ctrl write");
        access(0, 32'h100, 0, "R4 ctrl read ones");
        access(1, 32'h100, 32'hFFFF_FFFE, "R4 ctrl write");
        access(0, 32'h100, 0, "R4 ctrl read bit0 clear");
        // R6 fold and stickiness
        access(1, 32'h104, 32'h000F_0000, "R6 aux set");
        access(0, 32'h004, 0, "R6 ctype folded");
        access(1, 32'h104, 32'h0, "R6 aux clear");
        access(0, 32'h004, 0, "R6 ctype sticky");
        check(m_ct == 32'h1C740740, "R6 model value", m_ct, 32'h1C740740);
        // R5 maintenance range
        access(1, 32'h730, 32'hFFFF_FFFF, "R5 mnt write low");
        access(1, 32'h7FF, 32'hFFFF_FFFF, "R5 mnt write high");
        access(0, 32'h7FF, 0, "R5 mnt read");
        access(0, 32'h104, 0, "R5 aux unchanged");
        access(0, 32'h72C, 0, "R10 below mnt range");
        access(0, 32'h800, 0, "R10 above mnt range");
        // R9 quiet offsets
        access(1, 32'hF60, 32'h1234_5678, "R9 quiet write");
        access(0, 32'hF80, 0, "R9 quiet read");
        // R10 bad writes to read-only offsets
        access(1, 32'h000, 32'hFFFF_FFFF, "R10 write id");
        access(1, 32'h004, 32'hFFFF_FFFF, "R10 write ctype");
        access(0, 32'h004, 0, "R10 ctype unchanged");
        access(1, 32'h200, 32'hFFFF_FFFF, "R10 write unmapped");
        access(0, 32'h200, 0, "R10 read unmapped");
        // R11 hold on idle
        access(0, 32'h108, 0, "R11 read");
        @(negedge clk);
        check(rdata == last_rd, "R11 hold idle", rdata, last_rd);
        check(bad_acc == 0, "R10 idle flag", {31'd0, bad_acc}, 0);
        access(1, 32'h10C, 32'hCAFE_F00D, "R11 write");
        check(rdata == last_rd, "R11 hold over write", rdata, last_rd);

        // random mix
        for (int i = 0; i < 400; i++) begin
            int unsigned r = $urandom;
            logic [31:0] a = {$urandom_range(0, 32'hFFFFF)[19:0], pick_ofs(r)};
            access(r[31], a, $urandom, "R3/R6/R10 random");
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule